// File: doc/BRIEF.md
# Fetch Group Terminator

This block sits after the instruction cache and predictor lookups of a wide fetch stage. Each cycle it sees a window of two consecutive, line-aligned cache lines, and for every slot in that window it sees a pre-decoded instruction class. It also receives the predictor's direction bits, one per conditional branch in program order, the per-slot branch target buffer lookups, and the top of the return stack. From these it works out which slots of the window belong to the current fetch group and where fetch goes on the next cycle.

A group opens at the slot the fetch address points to in the first line. It runs forward through the window, across the line boundary if no stop comes first, and closes at the first of these: the instruction limit, the conditional-branch limit, a branch predicted taken, a direct jump or call, an indirect jump whose target buffer entry is missing or marks the target as breaking sequence, a return, or a system call. An indirect jump whose entry hits and does not break sequence is fetched through. The next address is taken from one of four sources: the sequential address after the last slot, a PC-relative target computed from the instruction's offset, the target buffer, or the return stack.

Top module: `fetch_group_end`

## Requirements
- R1: `out_valid`, `out_mask` and `out_next_pc` are registered. `out_valid` equals `in_valid` of the previous cycle, and reset drives `out_valid` low and `out_mask` and `out_next_pc` to zero.
- R2: Bit i of `out_mask` stands for the slot at address base + 4*i, where base is `fetch_pc` with its low five bits cleared. The mask is one contiguous run of ones that starts at slot `fetch_pc[4:2]` and includes the stopping slot. A slot below the start never affects the result, whatever its class.
- R3: If no stop condition occurs, the group takes every slot from the start through the end of the second line, up to `MAX_INSNS` slots, and the next address is the one after the last slot.
- R4: Slot classes are coded 0 plain, 1 conditional branch, 2 direct jump, 3 direct call, 4 indirect jump, 5 return and 6 system call. The group closes at its `MAX_BR`-th conditional branch even when that branch is predicted not taken, and the next address is sequential.
- R5: The k-th conditional branch in the group, counting from 0, uses `pred_dir[k]`. A taken prediction closes the group there, with next address = slot address + 4 * sign-extended `slot_off` of that slot.
- R6: A direct jump or direct call closes the group, with next address = slot address + 4 * sign-extended offset.
- R7: An indirect jump with `btb_hit` and `btb_brk` set closes the group and takes that slot's `btb_tgt`. With `btb_hit` set and `btb_brk` clear, the group continues past it.
- R8: An indirect jump with `btb_hit` clear closes the group, and the next address is the slot after it.
- R9: A return closes the group, and the next address is `ras_top`.
- R10: A system call closes the group, and the next address is the slot after it.
- R11: When several stop conditions are present, the lowest-addressed one at or after the start decides both the mask and the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window inputs are valid this cycle |
| fetch_pc | input | ADDR_W | Fetch address; selects the window base and the start slot |
| slot_kind | input | 2*LINE_SLOTS*3 | Pre-decoded class per slot, slot 0 in the low bits |
| slot_off | input | 2*LINE_SLOTS*OFF_W | Signed PC-relative offset per slot, in instructions |
| btb_hit | input | 2*LINE_SLOTS | Target buffer hit per slot |
| btb_brk | input | 2*LINE_SLOTS | Target buffer sequence-break bit per slot |
| btb_tgt | input | 2*LINE_SLOTS*ADDR_W | Target buffer predicted target per slot |
| pred_dir | input | MAX_BR | Direction predictions in branch order, 1 = taken |
| ras_top | input | ADDR_W | Top of the return address stack |
| out_valid | output | 1 | Group result valid |
| out_mask | output | 2*LINE_SLOTS | Valid-slot mask for the group |
| out_next_pc | output | ADDR_W | Fetch address for the next cycle |

## Verification
The bench sends a branch predicted taken that sits below the start slot. A design that scans from slot 0 would cut the group short there, or would use up the first prediction on it. It places a not-taken branch ahead of a taken one, which catches a design that indexes predictions by slot rather than by branch order, and it puts three not-taken branches in one group, which catches an off-by-one in the branch limit. It also fetches straight through a non-breaking indirect jump, sends a window with no stop at all so the group must cross the line boundary, and stacks several stop classes close together. A wrong priority there shows up as a mask that ends too late or a target taken from the wrong source.

// File: rtl/fetch_group_pkg.sv
package fetch_group_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_PLAIN = 3'd0,
      K_COND  = 3'd1,
      K_JMP   = 3'd2,
      K_CALL  = 3'd3,
      K_IND   = 3'd4,
      K_RET   = 3'd5,
      K_SYS   = 3'd6,
      K_RSV   = 3'd7
   } slot_kind_e;

   typedef enum logic [1:0] {
      NX_SEQ = 2'd0,
      NX_REL = 2'd1,
      NX_BTB = 2'd2,
      NX_RAS = 2'd3
   } next_src_e;
endpackage

// File: rtl/fetch_slot_class.sv
module fetch_slot_class
   import fetch_group_pkg::*;
(
   input  logic [KIND_W-1:0] kind,
   input  logic              hit,
   input  logic              brk,
   output logic              is_cond,
   output logic              hard_stop,
   output logic [1:0]        stop_src
);
   always_comb begin
      is_cond   = 1'b0;
      hard_stop = 1'b0;
      stop_src  = NX_SEQ;
      case (slot_kind_e'(kind))
         K_COND: is_cond = 1'b1;
         K_JMP, K_CALL: begin
            hard_stop = 1'b1;
            stop_src  = NX_REL;
         end
         K_IND: begin
            hard_stop = !(hit && !brk);
            stop_src  = hit ? NX_BTB : NX_SEQ;
         end
         K_RET: begin
            hard_stop = 1'b1;
            stop_src  = NX_RAS;
         end
         K_SYS: hard_stop = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/fetch_group_scan.sv
module fetch_group_scan
   import fetch_group_pkg::*;
#(
   parameter int WIN       = 16,
   parameter int MAX_INSNS = 16,
   parameter int MAX_BR    = 3,
   localparam int IDX_W    = $clog2(WIN),
   localparam int BR_W     = $clog2(MAX_BR + 1)
) (
   input  logic [IDX_W-1:0]        start,
   input  logic [WIN-1:0]          is_cond,
   input  logic [WIN-1:0]          hard_stop,
   input  logic [WIN-1:0][1:0]     stop_src,
   input  logic [MAX_BR-1:0]       pred_dir,
   output logic [WIN-1:0]          mask,
   output logic [IDX_W-1:0]        last_idx,
   output logic [1:0]              end_src
);
   logic [WIN-1:0] cap_at;

   generate
      if (MAX_INSNS >= WIN) begin : g_nocap
         assign cap_at = '0;
      end else begin : g_cap
         for (genvar i = 0; i < WIN; i++) begin : g_slot
            assign cap_at[i] = ((IDX_W+1)'(i)) ==
                               ({1'b0, start} + (IDX_W+1)'(MAX_INSNS - 1));
         end
      end
   endgenerate

   always_comb begin
      logic            done;
      logic [BR_W-1:0] nbr;
      done     = 1'b0;
      nbr      = '0;
      mask     = '0;
      last_idx = '0;
      end_src  = NX_SEQ;
      for (int i = 0; i < WIN; i++) begin
         if (!done && (IDX_W'(i) >= start)) begin
            mask[i]  = 1'b1;
            last_idx = IDX_W'(i);
            end_src  = NX_SEQ;
            if (is_cond[i]) begin
               if (pred_dir[nbr]) begin
                  done    = 1'b1;
                  end_src = NX_REL;
               end
               nbr = nbr + 1'b1;
               if (nbr == BR_W'(MAX_BR)) done = 1'b1;
            end
            if (hard_stop[i]) begin
               done    = 1'b1;
               end_src = stop_src[i];
            end
            if (cap_at[i]) done = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fetch_next_sel.sv
module fetch_next_sel
   import fetch_group_pkg::*;
#(
   parameter int WIN      = 16,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int BYTE_LSB = 2,
   localparam int IDX_W   = $clog2(WIN)
) (
   input  logic [ADDR_W-1:0]           base,
   input  logic [IDX_W-1:0]            last_idx,
   input  logic [1:0]                  end_src,
   input  logic [WIN-1:0][OFF_W-1:0]   offs,
   input  logic [WIN-1:0][ADDR_W-1:0]  tgts,
   input  logic [ADDR_W-1:0]           ras_top,
   output logic [ADDR_W-1:0]           next_pc
);
   logic [ADDR_W-1:0] last_pc;
   logic [OFF_W-1:0]  off;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      last_pc = base + (ADDR_W'(last_idx) << BYTE_LSB);
      off     = offs[last_idx];
      rel     = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off} << BYTE_LSB;
      case (next_src_e'(end_src))
         NX_REL:  next_pc = last_pc + rel;
         NX_BTB:  next_pc = tgts[last_idx];
         NX_RAS:  next_pc = ras_top;
         default: next_pc = last_pc + ADDR_W'(1 << BYTE_LSB);
      endcase
   end
endmodule

// File: rtl/fetch_group_end.sv
module fetch_group_end
   import fetch_group_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_SLOTS = 8,
   parameter int INSN_BYTES = 4,
   parameter int MAX_INSNS  = 16,
   parameter int MAX_BR     = 3,
   parameter int OFF_W      = 16,
   localparam int WIN       = 2 * LINE_SLOTS,
   localparam int IDX_W     = $clog2(WIN),
   localparam int BYTE_LSB  = $clog2(INSN_BYTES),
   localparam int LINE_LSB  = BYTE_LSB + $clog2(LINE_SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [ADDR_W-1:0]       fetch_pc,
   input  logic [WIN*KIND_W-1:0]   slot_kind,
   input  logic [WIN*OFF_W-1:0]    slot_off,
   input  logic [WIN-1:0]          btb_hit,
   input  logic [WIN-1:0]          btb_brk,
   input  logic [WIN*ADDR_W-1:0]   btb_tgt,
   input  logic [MAX_BR-1:0]       pred_dir,
   input  logic [ADDR_W-1:0]       ras_top,
   output logic                    out_valid,
   output logic [WIN-1:0]          out_mask,
   output logic [ADDR_W-1:0]       out_next_pc
);
   generate
      if (LINE_SLOTS < 2 || (1 << $clog2(LINE_SLOTS)) != LINE_SLOTS) begin : g_bad_line
         $error("LINE_SLOTS must be a power of two of at least 2");
      end
      if ((1 << BYTE_LSB) != INSN_BYTES) begin : g_bad_insn
         $error("INSN_BYTES must be a power of two");
      end
      if (MAX_BR < 1 || MAX_INSNS < 1) begin : g_bad_lim
         $error("MAX_BR and MAX_INSNS must be positive");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_off
         $error("OFF_W must be narrower than ADDR_W");
      end
   endgenerate

   logic [WIN-1:0]             is_cond, hard_stop;
   logic [WIN-1:0][1:0]        stop_src;
   logic [WIN-1:0][OFF_W-1:0]  offs;
   logic [WIN-1:0][ADDR_W-1:0] tgts;
   logic [ADDR_W-1:0]          base;
   logic [IDX_W-1:0]           start;
   logic [WIN-1:0]             mask_c;
   logic [IDX_W-1:0]           last_idx;
   logic [1:0]                 end_src;
   logic [ADDR_W-1:0]          next_c;
   logic                       unused_lo;

   assign offs      = slot_off;
   assign tgts      = btb_tgt;
   assign base      = {fetch_pc[ADDR_W-1:LINE_LSB], LINE_LSB'(0)};
   assign start     = {1'b0, fetch_pc[LINE_LSB-1:BYTE_LSB]};
   assign unused_lo = ^fetch_pc[BYTE_LSB-1:0];

   for (genvar i = 0; i < WIN; i++) begin : g_cls
      fetch_slot_class u_cls (
         .kind      (slot_kind[i*KIND_W +: KIND_W]),
         .hit       (btb_hit[i]),
         .brk       (btb_brk[i]),
         .is_cond   (is_cond[i]),
         .hard_stop (hard_stop[i]),
         .stop_src  (stop_src[i])
      );
   end

   fetch_group_scan #(.WIN(WIN), .MAX_INSNS(MAX_INSNS), .MAX_BR(MAX_BR)) u_scan (
      .start     (start),
      .is_cond   (is_cond),
      .hard_stop (hard_stop),
      .stop_src  (stop_src),
      .pred_dir  (pred_dir),
      .mask      (mask_c),
      .last_idx  (last_idx),
      .end_src   (end_src)
   );

   fetch_next_sel #(.WIN(WIN), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTE_LSB(BYTE_LSB)) u_nsel (
      .base     (base),
      .last_idx (last_idx),
      .end_src  (end_src),
      .offs     (offs),
      .tgts     (tgts),
      .ras_top  (ras_top),
      .next_pc  (next_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_mask    <= '0;
         out_next_pc <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mask    <= mask_c;
            out_next_pc <= next_c;
         end
      end
   end
endmodule

// File: rtl/fetch_group_end_chk.sv
module fetch_group_end_chk
   import fetch_group_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_SLOTS = 8,
   parameter int INSN_BYTES = 4,
   parameter int MAX_INSNS  = 16,
   parameter int MAX_BR     = 3,
   localparam int WIN       = 2 * LINE_SLOTS,
   localparam int IDX_W     = $clog2(WIN),
   localparam int BYTE_LSB  = $clog2(INSN_BYTES),
   localparam int LINE_LSB  = BYTE_LSB + $clog2(LINE_SLOTS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [ADDR_W-1:0]     fetch_pc,
   input logic [WIN*KIND_W-1:0] slot_kind,
   input logic                  out_valid,
   input logic [WIN-1:0]        out_mask
);
   logic [IDX_W-1:0]      start_q;
   logic [WIN*KIND_W-1:0] kind_q;
   logic [WIN-1:0]        below;
   logic [WIN:0]          edges;
   int                    n_cond;
   logic                  stop_inside;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         kind_q  <= '0;
      end else if (in_valid) begin
         start_q <= {1'b0, fetch_pc[LINE_LSB-1:BYTE_LSB]};
         kind_q  <= slot_kind;
      end
   end

   always_comb begin
      below       = (WIN'(1) << start_q) - WIN'(1);
      edges       = {1'b0, out_mask} ^ {out_mask, 1'b0};
      n_cond      = 0;
      stop_inside = 1'b0;
      for (int i = 0; i < WIN; i++) begin
         if (out_mask[i] && kind_q[i*KIND_W +: KIND_W] == K_COND) n_cond++;
         if (i < WIN - 1 && out_mask[i] && out_mask[i+1]) begin
            case (slot_kind_e'(kind_q[i*KIND_W +: KIND_W]))
               K_JMP, K_CALL, K_RET, K_SYS: stop_inside = 1'b1;
               default: ;
            endcase
         end
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(edges) == 2));
   assert_starts_at_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mask[start_q] && ((out_mask & below) == '0)));
   assert_insn_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_mask) <= MAX_INSNS));
   assert_branch_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (n_cond <= MAX_BR));
   assert_hard_stop_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !stop_inside);
endmodule

bind fetch_group_end fetch_group_end_chk #(
   .ADDR_W(ADDR_W), .LINE_SLOTS(LINE_SLOTS), .INSN_BYTES(INSN_BYTES),
   .MAX_INSNS(MAX_INSNS), .MAX_BR(MAX_BR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_pc(fetch_pc),
   .slot_kind(slot_kind), .out_valid(out_valid), .out_mask(out_mask)
);

// File: tb/fetch_group_end_tb.sv
`timescale 1ns/1ps
module fetch_group_end_tb;
   localparam int WIN = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [31:0]       fetch_pc = '0;
   logic [WIN*3-1:0]  slot_kind = '0;
   logic [WIN*16-1:0] slot_off;
   logic [WIN-1:0]    btb_hit = '0, btb_brk = '0;
   logic [WIN*32-1:0] btb_tgt;
   logic [2:0]        pred_dir = '0;
   logic [31:0]       ras_top = 32'h0000_4440;
   logic              out_valid;
   logic [WIN-1:0]    out_mask;
   logic [31:0]       out_next_pc;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   fetch_group_end u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_pc(fetch_pc),
      .slot_kind(slot_kind), .slot_off(slot_off), .btb_hit(btb_hit),
      .btb_brk(btb_brk), .btb_tgt(btb_tgt), .pred_dir(pred_dir),
      .ras_top(ras_top), .out_valid(out_valid), .out_mask(out_mask),
      .out_next_pc(out_next_pc)
   );

   initial begin
      for (int i = 0; i < WIN; i++) begin
         slot_off[i*16 +: 16] = 16'(8 * (i + 1));
         btb_tgt[i*32 +: 32]  = 32'h8000_0000 + 32'(i * 256);
      end
   end

   typedef struct packed {
      logic [3:0]  start;
      logic [63:0] kinds;   // one nibble per slot, slot 0 lowest
      logic [2:0]  pred;
      logic [15:0] hit;
      logic [15:0] brk;
      logic [15:0] mask;
      logic [31:0] nxt;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 64'h0, 3'b000, 16'h0, 16'h0, 16'hffff, 32'h0000_1040},                   // R3 full window
      '{4'd5, 64'h0, 3'b000, 16'h0, 16'h0, 16'hffe0, 32'h0000_1040},                   // R2 start offset
      '{4'd0, 64'h0001_0010_0010_0100, 3'b000, 16'h0, 16'h0, 16'h03ff, 32'h0000_1028}, // R4 third branch
      '{4'd0, 64'h0000_0000_0000_1000, 3'b001, 16'h0, 16'h0, 16'h000f, 32'h0000_108c}, // R5 taken
      '{4'd0, 64'h0000_0000_0100_0010, 3'b010, 16'h0, 16'h0, 16'h007f, 32'h0000_10f8}, // R5 second branch
      '{4'd2, 64'h0000_0000_0002_0000, 3'b000, 16'h0, 16'h0, 16'h001c, 32'h0000_10b0}, // R6 jump
      '{4'd0, 64'h0000_0300_0000_0000, 3'b000, 16'h0, 16'h0, 16'h07ff, 32'h0000_1188}, // R6 call
      '{4'd0, 64'h0000_0000_4000_0000, 3'b000, 16'h0080, 16'h0080, 16'h00ff, 32'h8000_0700}, // R7 break
      '{4'd0, 64'h0006_0000_4000_0000, 3'b000, 16'h0080, 16'h0000, 16'h1fff, 32'h0000_1034}, // R7 pass, R10
      '{4'd0, 64'h0000_0000_0000_4000, 3'b000, 16'h0, 16'h0, 16'h000f, 32'h0000_1010}, // R8 miss
      '{4'd1, 64'h0000_0050_0000_0000, 3'b000, 16'h0, 16'h0, 16'h03fe, 32'h0000_4440}, // R9 return
      '{4'd0, 64'h0000_0000_0000_0006, 3'b000, 16'h0, 16'h0, 16'h0001, 32'h0000_1004}, // R10 syscall
      '{4'd4, 64'h0000_0002_0560_0000, 3'b000, 16'h0, 16'h0, 16'h0030, 32'h0000_1018}, // R11 earliest
      '{4'd3, 64'h0000_0000_0000_0010, 3'b001, 16'h0, 16'h0, 16'hfff8, 32'h0000_1040}  // R2 branch below start
   };
   localparam string TAGS [NV] = '{"R3", "R2", "R4", "R5", "R5", "R6", "R6",
                                   "R7", "R7", "R8", "R9", "R10", "R11", "R2"};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      in_valid = 1'b1;
      fetch_pc = 32'h0000_1000 + 32'(v.start) * 4;
      for (int i = 0; i < WIN; i++) slot_kind[i*3 +: 3] = v.kinds[i*4 +: 3];
      pred_dir = v.pred;
      btb_hit  = v.hit;
      btb_brk  = v.brk;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 reset valid", {31'b0, out_valid}, 32'h0);
      check("R1 reset mask", {16'b0, out_mask}, 32'h0);
      check("R1 reset next", out_next_pc, 32'h0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         drive(VECS[k]);
         @(negedge clk);
         check({TAGS[k], " valid"}, {31'b0, out_valid}, 32'h1);
         check({TAGS[k], " mask"}, {16'b0, out_mask}, {16'b0, VECS[k].mask});
         check({TAGS[k], " next"}, out_next_pc, VECS[k].nxt);
         in_valid = 1'b0;
      end

      // R1 valid drops one cycle after in_valid drops
      @(negedge clk);
      check("R1 idle", {31'b0, out_valid}, 32'h0);

      // R1 asynchronous reset clears a loaded result
      drive(VECS[6]);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 reset mask clear", {16'b0, out_mask}, 32'h0);
      check("R1 reset next clear", out_next_pc, 32'h0);
      finish_run();
   end
endmodule